// File: doc/BRIEF.md
# Run-Length Pattern Stimulus Source

This block drives a single output bit from a stored bit pattern, advancing one pattern position per clock cycle. The pattern is held as a table of runs: each run is one bit value and a repeat count. The run table, and a register holding how many table entries are in use, are written through a plain synchronous write port before playback starts.

Two playback modes are offered. In cyclic mode the expanded pattern repeats without end, so its total expanded length is the period of the output. In one-shot mode the pattern plays through once and the output then keeps the last bit it produced until playback is started again. A run whose count is zero is not legal: it is skipped and occupies no cycles. Before playback is first started, the output shows the bit of the first run that would be played.

A pattern such as 0001111111 takes two runs (three zeros, then seven ones). A run repeats a single bit only, so an alternating pattern needs one run per bit.

Top module: `rlp_pattern_source`

## Requirements
- R1: After a synchronous reset the output `pat_out` is 0, the entry count is 0 and every run is cleared, so a start before any write leaves `pat_out` at 0.
- R2: While idle, and at least two cycles after the last table write, `pat_out` equals the bit of the playable run with the lowest index; a run is playable when its count is nonzero and its index is below the entry count.
- R3: When `start` is high at a clock edge while idle, `pat_out` shows the first playable run's bit from that edge on; every playable run then drives its bit for exactly its count of cycles, and runs follow one another with no gap, including runs of count 1.
- R4: With `cyc_mode` = 1, the run after the last playable run is the first playable run again, so the output repeats with a period equal to the sum of the playable counts.
- R5: With `cyc_mode` = 0, once the last cycle of the last playable run has been output, `pat_out` keeps that bit for as long as `start` stays low.
- R6: A `start` after a one-shot playback has ended replays the pattern from its first playable run.
- R7: Runs with count 0 and runs at an index not below the entry count are never played and take no cycles.
- R8: A `start` pulse during playback has no effect on the output sequence.
- R9: A `start` when no run is playable is ignored and `pat_out` stays 0.
- R10: A run count may take any value from 1 to 2^CNT_W-1, and the longest run lasts exactly that many cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_mode | input | 1 | 1: repeat the pattern forever; 0: play once then hold |
| start | input | 1 | Begin playback from the first playable run (honoured when idle or holding) |
| wr_en | input | 1 | Write one run into the table |
| wr_addr | input | IDX_W | Table index of the run being written |
| wr_bit | input | 1 | Bit value of the run being written |
| wr_cnt | input | CNT_W | Repeat count of the run being written (0 marks it unplayable) |
| len_we | input | 1 | Load the entry count |
| len_val | input | LEN_W | New entry count (entries 0 to len_val-1 are in use) |
| pat_out | output | 1 | Registered pattern output bit |

## Verification
The bench builds the block with its default sizes, a 16-entry table and 15-bit counts, so a pattern can fill every table slot and a single run can reach the full 32767-cycle maximum. With these values it reaches the wrap from the last slot back to the first, back-to-back runs of count 1 where the prefetched count must be ready in the very next cycle, zero-count slots and slots past the entry count in the middle of a pattern, and the longest legal run in one-shot mode.

// File: rtl/rlp_pkg.sv
package rlp_pkg;

  typedef enum logic [1:0] {
    RLP_IDLE = 2'd0,
    RLP_PLAY = 2'd1,
    RLP_HOLD = 2'd2
  } rlp_state_e;

endpackage

// File: rtl/rlp_run_table.sv
module rlp_run_table #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 15,
  parameter int IDX_W = 4,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic             wr_bit,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             len_we,
  input  logic [LEN_W-1:0] len_val,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [CNT_W-1:0] rd_cnt,
  output logic [DEPTH-1:0] bit_vec,
  output logic [DEPTH-1:0] live_vec
);

  // Counts live in a memory with one write and one registered read port,
  // the shape that maps onto a block RAM. Values and nonzero flags are
  // kept in flops so the next-run search can look at all entries at once.
  logic [CNT_W-1:0] cnt_mem [DEPTH];
  logic [DEPTH-1:0] bit_q;
  logic [DEPTH-1:0] nz_q;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      cnt_mem[wr_addr] <= wr_cnt;
    end
    rd_cnt <= cnt_mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= '0;
      nz_q  <= '0;
      len_q <= '0;
    end else begin
      if (wr_en) begin
        bit_q[wr_addr] <= wr_bit;
        nz_q[wr_addr]  <= (wr_cnt != '0);
      end
      if (len_we) begin
        len_q <= len_val;
      end
    end
  end

  assign bit_vec = bit_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_live
    localparam logic [LEN_W-1:0] SLOT = LEN_W'(g);
    assign live_vec[g] = nz_q[g] && (SLOT < len_q);
  end

endmodule

// File: rtl/rlp_run_finder.sv
module rlp_run_finder #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic [DEPTH-1:0] live_vec,
  input  logic [IDX_W-1:0] from_idx,
  output logic             any_live,
  output logic [IDX_W-1:0] first_idx,
  output logic [IDX_W-1:0] succ_idx,
  output logic             succ_wraps
);

  logic             after_hit;
  logic [IDX_W-1:0] after_idx;

  always_comb begin
    any_live  = |live_vec;
    first_idx = '0;
    after_hit = 1'b0;
    after_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (live_vec[i]) begin
        first_idx = IDX_W'(i);
      end
      if (live_vec[i] && (i > int'(from_idx))) begin
        after_hit = 1'b1;
        after_idx = IDX_W'(i);
      end
    end
    succ_wraps = !after_hit;
    succ_idx   = after_hit ? after_idx : first_idx;
  end

endmodule

// File: rtl/rlp_sequencer.sv
module rlp_sequencer
  import rlp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 15,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cyc_mode,
  input  logic [DEPTH-1:0] bit_vec,
  input  logic             any_live,
  input  logic [IDX_W-1:0] first_idx,
  input  logic [IDX_W-1:0] succ_idx,
  input  logic             succ_wraps,
  input  logic [CNT_W-1:0] rd_cnt,
  output rlp_state_e       state_q,
  output rlp_state_e       state_d,
  output logic [IDX_W-1:0] cur_q,
  output logic [IDX_W-1:0] cur_d,
  output logic [CNT_W-1:0] rem_q,
  output logic             out_q
);

  logic [CNT_W-1:0] rem_d;
  logic             out_d;
  logic             launch;

  // rd_cnt always holds the count of the run that would be loaded next:
  // the first playable run outside playback, the successor during it.
  assign launch = start && any_live && (state_q != RLP_PLAY);

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    rem_d   = rem_q;
    out_d   = out_q;
    if (launch) begin
      state_d = RLP_PLAY;
      cur_d   = first_idx;
      rem_d   = rd_cnt;
      out_d   = bit_vec[first_idx];
    end else begin
      unique case (state_q)
        RLP_IDLE: begin
          out_d = any_live ? bit_vec[first_idx] : 1'b0;
        end
        RLP_PLAY: begin
          if (!any_live) begin
            state_d = RLP_IDLE;
          end else if (rem_q > CNT_W'(1)) begin
            rem_d = rem_q - 1'b1;
          end else if (succ_wraps && !cyc_mode) begin
            state_d = RLP_HOLD;
          end else begin
            cur_d = succ_idx;
            rem_d = rd_cnt;
            out_d = bit_vec[succ_idx];
          end
        end
        RLP_HOLD: begin
          out_d = out_q;
        end
        default: begin
          state_d = RLP_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RLP_IDLE;
      cur_q   <= '0;
      rem_q   <= '0;
      out_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      rem_q   <= rem_d;
      out_q   <= out_d;
    end
  end

endmodule

// File: rtl/rlp_pattern_source.sv
module rlp_pattern_source
  import rlp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 15,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_mode,
  input  logic             start,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic             wr_bit,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             len_we,
  input  logic [LEN_W-1:0] len_val,
  output logic             pat_out
);

  logic [DEPTH-1:0] bit_vec;
  logic [DEPTH-1:0] live_vec;
  logic [CNT_W-1:0] rd_cnt;
  logic [IDX_W-1:0] rd_addr;

  rlp_state_e       seq_state;
  rlp_state_e       seq_state_d;
  logic [IDX_W-1:0] seq_idx;
  logic [IDX_W-1:0] seq_idx_d;
  logic [CNT_W-1:0] seq_rem;

  logic             now_any;
  logic [IDX_W-1:0] now_first;
  logic [IDX_W-1:0] now_succ;
  logic             now_wraps;
  logic             ahd_any;
  logic [IDX_W-1:0] ahd_first;
  logic [IDX_W-1:0] ahd_succ;
  logic             ahd_wraps;

  rlp_run_table #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W), .LEN_W(LEN_W)
  ) table_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_bit   (wr_bit),
    .wr_cnt   (wr_cnt),
    .len_we   (len_we),
    .len_val  (len_val),
    .rd_addr  (rd_addr),
    .rd_cnt   (rd_cnt),
    .bit_vec  (bit_vec),
    .live_vec (live_vec)
  );

  // Successor of the run playing now: used when the current run ends.
  rlp_run_finder #(.DEPTH(DEPTH), .IDX_W(IDX_W)) find_now_i (
    .live_vec   (live_vec),
    .from_idx   (seq_idx),
    .any_live   (now_any),
    .first_idx  (now_first),
    .succ_idx   (now_succ),
    .succ_wraps (now_wraps)
  );

  // Successor of the run that will be playing after this edge: its count
  // is fetched now so a run of length 1 can hand over without a bubble.
  rlp_run_finder #(.DEPTH(DEPTH), .IDX_W(IDX_W)) find_ahead_i (
    .live_vec   (live_vec),
    .from_idx   (seq_idx_d),
    .any_live   (ahd_any),
    .first_idx  (ahd_first),
    .succ_idx   (ahd_succ),
    .succ_wraps (ahd_wraps)
  );

  assign rd_addr = (seq_state_d == RLP_PLAY) ? ahd_succ : now_first;

  rlp_sequencer #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) seq_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .cyc_mode   (cyc_mode),
    .bit_vec    (bit_vec),
    .any_live   (now_any),
    .first_idx  (now_first),
    .succ_idx   (now_succ),
    .succ_wraps (now_wraps),
    .rd_cnt     (rd_cnt),
    .state_q    (seq_state),
    .state_d    (seq_state_d),
    .cur_q      (seq_idx),
    .cur_d      (seq_idx_d),
    .rem_q      (seq_rem),
    .out_q      (pat_out)
  );

  logic unused_ahead;
  assign unused_ahead = ahd_any ^ ahd_wraps ^ (^ahd_first);

endmodule

// File: rtl/rlp_pattern_source_chk.sv
module rlp_pattern_source_chk
  import rlp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 15,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             pat_out,
  input rlp_state_e       seq_state,
  input logic [IDX_W-1:0] seq_idx,
  input logic [CNT_W-1:0] seq_rem,
  input logic [DEPTH-1:0] live_vec
);

  // R3: a run being played always has at least one cycle left.
  p_play_count_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    (seq_state == RLP_PLAY) |-> (seq_rem != '0));

  // R3: inside a run the output does not change.
  p_run_holds_bit_r3: assert property (@(posedge clk) disable iff (rst)
    (seq_state == RLP_PLAY && seq_rem > CNT_W'(1)) |=> $stable(pat_out));

  // R5: after a one-shot playback ends the output is frozen until start.
  p_hold_keeps_bit_r5: assert property (@(posedge clk) disable iff (rst)
    (seq_state == RLP_HOLD && !start) |=> $stable(pat_out));

  // R7: only playable runs are ever selected for playback.
  p_plays_live_run_r7: assert property (@(posedge clk) disable iff (rst)
    (seq_state == RLP_PLAY) |-> live_vec[seq_idx]);

  // R8: start during a run neither restarts nor stretches it.
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (seq_state == RLP_PLAY && seq_rem > CNT_W'(1))
    |=> (seq_state == RLP_PLAY && seq_rem + 1'b1 == $past(seq_rem)));

endmodule

bind rlp_pattern_source rlp_pattern_source_chk #(
  .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .pat_out   (pat_out),
  .seq_state (seq_state),
  .seq_idx   (seq_idx),
  .seq_rem   (seq_rem),
  .live_vec  (live_vec)
);

// File: tb/rlp_pattern_source_tb_top.sv
module rlp_pattern_source_tb_top;

  localparam int DEPTH = 16;
  localparam int CNT_W = 15;
  localparam int IDX_W = 4;
  localparam int LEN_W = 5;

  typedef struct {
    logic  v;
    string tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cyc_mode = 1'b0;
  logic             start = 1'b0;
  logic             wr_en = 1'b0;
  logic [IDX_W-1:0] wr_addr = '0;
  logic             wr_bit = 1'b0;
  logic [CNT_W-1:0] wr_cnt = '0;
  logic             len_we = 1'b0;
  logic [LEN_W-1:0] len_val = '0;
  logic             pat_out;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  exp_t exp_q[$];

  // Bench copy of the table, filled only from the stimulus.
  logic tv [DEPTH];
  int   tc [DEPTH];
  int   tlen = 0;

  always #4 clk = ~clk;

  rlp_pattern_source #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .cyc_mode (cyc_mode),
    .start    (start),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_bit   (wr_bit),
    .wr_cnt   (wr_cnt),
    .len_we   (len_we),
    .len_val  (len_val),
    .pat_out  (pat_out)
  );

  // Monitor: one expected bit per cycle, compared away from the edge.
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (pat_out !== e.v) begin
        n_errors++;
        $display("FAIL %s pattern bit got %0b want %0b", e.tag, pat_out, e.v);
      end
    end
  end

  task automatic check_now(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s got %0b want %0b", tag, act, exp);
    end
  endtask

  task automatic table_clear();
    for (int i = 0; i < DEPTH; i++) begin
      tv[i] = 1'b0;
      tc[i] = 0;
    end
    tlen = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    start = 1'b0;
    table_clear();
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic put_run(input int idx, input logic b, input int cnt);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = IDX_W'(idx);
    wr_bit  = b;
    wr_cnt  = CNT_W'(cnt);
    tv[idx] = b;
    tc[idx] = cnt;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put_len(input int n);
    @(negedge clk);
    len_we  = 1'b1;
    len_val = LEN_W'(n);
    tlen    = n;
    @(negedge clk);
    len_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Expected first idle bit from the bench table.
  function automatic logic idle_bit();
    for (int i = 0; i < tlen && i < DEPTH; i++) begin
      if (tc[i] != 0) return tv[i];
    end
    return 1'b0;
  endfunction

  // Expand the bench table into ncyc expected output bits.
  task automatic push_model(input string tag, input int ncyc);
    int   seq[$];
    int   k;
    int   rem;
    logic last;
    bit   done;
    for (int i = 0; i < tlen && i < DEPTH; i++) begin
      if (tc[i] != 0) seq.push_back(i);
    end
    k = 0;
    rem = tc[seq[0]];
    last = tv[seq[0]];
    done = 1'b0;
    for (int t = 0; t < ncyc; t++) begin
      exp_t e;
      if (!done) last = tv[seq[k]];
      e.v = last;
      e.tag = tag;
      exp_q.push_back(e);
      if (!done) begin
        rem--;
        if (rem == 0) begin
          k++;
          if (k == seq.size()) begin
            if (cyc_mode) k = 0;
            else done = 1'b1;
          end
          if (!done) rem = tc[seq[k]];
        end
      end
    end
  endtask

  task automatic play(input string tag, input int ncyc);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1;
    start = 1'b0;
    push_model(tag, ncyc);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    table_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_now("R1 reset output", pat_out, 1'b0);

    // R9 / R1: start with an empty table does nothing.
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check_now("R9 start with no playable run", pat_out, 1'b0);
    put_len(3);
    check_now("R1 runs cleared by reset", pat_out, 1'b0);

    // One-shot 1001: runs (1,1) (0,2) (1,1).
    put_run(0, 1'b1, 1);
    put_run(1, 1'b0, 2);
    put_run(2, 1'b1, 1);
    put_len(3);
    check_now("R2 idle shows first run bit", pat_out, 1'b1);
    cyc_mode = 1'b0;
    play("R3 R5 one-shot 1001", 16);
    drain();
    check_now("R5 hold after one-shot", pat_out, 1'b1);
    play("R6 replay after hold", 12);
    drain();

    // Cyclic 1111001 with a start pulse in the middle.
    do_reset();
    put_run(0, 1'b1, 4);
    put_run(1, 1'b0, 2);
    put_run(2, 1'b1, 1);
    put_len(3);
    cyc_mode = 1'b1;
    play("R4 cyclic 1111001", 28);
    repeat (4) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();

    // Cyclic 0001111111 as two runs.
    do_reset();
    put_run(0, 1'b0, 3);
    put_run(1, 1'b1, 7);
    put_len(2);
    check_now("R2 idle shows first run bit 0", pat_out, 1'b0);
    play("R4 cyclic 0001111111", 30);
    drain();

    // Zero-count runs and runs beyond the entry count.
    do_reset();
    put_run(0, 1'b1, 0);
    put_run(1, 1'b0, 3);
    put_run(2, 1'b1, 2);
    put_run(3, 1'b1, 0);
    put_run(4, 1'b0, 1);
    put_run(5, 1'b1, 5);
    put_len(5);
    check_now("R2 R7 idle skips zero-count run", pat_out, 1'b0);
    cyc_mode = 1'b0;
    play("R7 one-shot skips unplayable runs", 14);
    drain();
    check_now("R7 R5 hold on last playable bit", pat_out, 1'b0);
    cyc_mode = 1'b1;
    play("R7 R4 cyclic skips unplayable runs", 20);
    drain();

    // Back-to-back runs of count 1.
    do_reset();
    put_run(0, 1'b0, 1);
    put_run(1, 1'b1, 1);
    put_run(2, 1'b0, 1);
    put_run(3, 1'b1, 1);
    put_len(4);
    cyc_mode = 1'b1;
    play("R3 R4 alternating count-1 runs", 20);
    drain();

    // Single run of count 1 in each mode.
    do_reset();
    put_run(0, 1'b1, 1);
    put_len(1);
    cyc_mode = 1'b1;
    play("R4 single run cyclic", 6);
    drain();
    do_reset();
    put_run(0, 1'b1, 1);
    put_len(1);
    cyc_mode = 1'b0;
    play("R5 single run one-shot", 6);
    drain();

    // Full table, one gap.
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      put_run(i, logic'(i % 2), (i == 7) ? 0 : (i % 3) + 1);
    end
    put_len(DEPTH);
    cyc_mode = 1'b1;
    play("R4 R7 full table cyclic", 70);
    drain();

    // Longest run.
    do_reset();
    put_run(0, 1'b1, (1 << CNT_W) - 1);
    put_run(1, 1'b0, 1);
    put_len(2);
    cyc_mode = 1'b0;
    play("R10 longest run", (1 << CNT_W) + 4);
    drain();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired got running want done");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule